// File: doc/BRIEF.md
# Floating-Point NaN Classifier and Quieter

This block looks at one IEEE 754 binary floating-point operand (double precision by default) and says which of six classes it falls into: zero, subnormal, normal, infinity, quiet NaN or signaling NaN. The meaning of the quiet/signaling indicator, the most significant fraction bit, is chosen at run time by a mode pin. When the mode pin is high the block uses the 2008-style encoding. When it is low it uses the legacy encoding, in which the polarity is reversed.

When the quiet request is high and the operand is a signaling NaN, the block returns the operand converted to a quiet NaN under the active encoding and raises an invalid-operation flag. Every other operand passes through unchanged. The block is purely combinational, so it has no stream handshake: its outputs follow its inputs in the same cycle, and the caller places it inside whatever pipeline stage needs it. The word is split into its fields through the parameters `EXP_W` and `FRAC_W`.

Top module: `dp_nan_quieter`

## Requirements
- R1: An operand with an all-zero exponent field and an all-zero fraction is reported with class code 0 (zero), whatever its sign.
- R2: An operand with an all-zero exponent field and a nonzero fraction is reported with class code 1 (subnormal).
- R3: An operand whose exponent field is neither all zeros nor all ones is reported with class code 2 (normal).
- R4: An operand with an all-ones exponent field and an all-zero fraction is reported with class code 3 (infinity).
- R5: An operand with an all-ones exponent field and a nonzero fraction is a NaN. Its indicator is fraction bit FRAC_W-1 (bit 51 by default). With mode=1, indicator=1 gives class 4 (quiet NaN) and indicator=0 gives class 5 (signaling NaN). With mode=0 the meanings are swapped: indicator=0 gives class 4 and indicator=1 gives class 5.
- R6: Every operand receives exactly one class code, and that code lies in the range 0 to 5.
- R7: Quieting a signaling NaN with mode=1 sets fraction bit FRAC_W-1 and leaves every other bit unchanged.
- R8: Quieting a signaling NaN with mode=0 clears fraction bit FRAC_W-1. If the fraction is then all zeros, the block also sets fraction bit FRAC_W-2 (bit 50 by default), so the result is still a NaN. All other bits are unchanged.
- R9: The invalid flag is high exactly when the quiet request is high and the operand is a signaling NaN under the active mode.
- R10: When no quieting takes place, the result equals the operand bit for bit. The sign bit is never altered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_i | input | EXP_W+FRAC_W+1 | Operand: sign, exponent field, fraction |
| nan2008_i | input | 1 | 1: indicator set means quiet; 0: legacy polarity |
| quiet_req_i | input | 1 | Request to quiet a signaling NaN |
| class_o | output | 3 | Class code 0 to 5 (see R1 to R5) |
| result_o | output | EXP_W+FRAC_W+1 | Quieted operand, or the operand unchanged |
| invalid_o | output | 1 | Invalid-operation flag raised by quieting |

## Verification
The bench builds one instance with EXP_W=3 and FRAC_W=4. This gives an 8-bit word, so it can drive all 256 operands under both modes and both request levels. That sweep reaches every class, both indicator polarities, and the legacy case in which clearing the indicator would leave an infinity. A second instance with the default 64-bit layout receives a few directed operands. These confirm that the indicator sits at bit 51 and that the fallback bit sits at bit 50.

// File: rtl/fpq_pkg.sv
package fpq_pkg;
  typedef enum logic [2:0] {
    CLS_ZERO = 3'd0,
    CLS_SUB  = 3'd1,
    CLS_NORM = 3'd2,
    CLS_INF  = 3'd3,
    CLS_QNAN = 3'd4,
    CLS_SNAN = 3'd5
  } fp_class_e;

  localparam int unsigned NUM_CLASSES = 6;
endpackage

// File: rtl/fpq_fields.sv
module fpq_fields #(
  parameter int unsigned EXP_W  = 11,
  parameter int unsigned FRAC_W = 52,
  localparam int unsigned WORD_W = EXP_W + FRAC_W + 1
) (
  input  logic [WORD_W-1:0] word_i,
  output logic              sign_o,
  output logic [EXP_W-1:0]  exp_o,
  output logic [FRAC_W-1:0] frac_o,
  output logic              exp_zero_o,
  output logic              exp_ones_o,
  output logic              frac_zero_o
);
  assign sign_o      = word_i[WORD_W-1];
  assign exp_o       = word_i[WORD_W-2 -: EXP_W];
  assign frac_o      = word_i[FRAC_W-1:0];
  assign exp_zero_o  = ~|exp_o;
  assign exp_ones_o  = &exp_o;
  assign frac_zero_o = ~|frac_o;
endmodule

// File: rtl/fpq_classify.sv
module fpq_classify
  import fpq_pkg::*;
#(
  parameter int unsigned FRAC_W = 52
) (
  input  logic [FRAC_W-1:0] frac_i,
  input  logic              exp_zero_i,
  input  logic              exp_ones_i,
  input  logic              frac_zero_i,
  input  logic              nan2008_i,
  output fp_class_e         class_o,
  output logic              is_snan_o
);
  logic [NUM_CLASSES-1:0] hit;
  logic                   is_nan;
  logic                   quiet_ind;

  assign is_nan    = exp_ones_i & ~frac_zero_i;
  assign quiet_ind = ~(nan2008_i ^ frac_i[FRAC_W-1]);

  always_comb begin
    hit = '0;
    hit[CLS_ZERO] = exp_zero_i & frac_zero_i;
    hit[CLS_SUB]  = exp_zero_i & ~frac_zero_i;
    hit[CLS_NORM] = ~exp_zero_i & ~exp_ones_i;
    hit[CLS_INF]  = exp_ones_i & frac_zero_i;
    hit[CLS_QNAN] = is_nan & quiet_ind;
    hit[CLS_SNAN] = is_nan & ~quiet_ind;
  end

  always_comb begin
    class_o = CLS_ZERO;
    for (int i = 0; i < NUM_CLASSES; i++) begin
      if (hit[i]) class_o = fp_class_e'(i);
    end
  end

  assign is_snan_o = hit[CLS_SNAN];

  always_comb begin
    p_one_class_r6: assert ($onehot(hit))
      else $error("class decode not one-hot: %b", hit);
  end
endmodule

// File: rtl/fpq_quiet.sv
module fpq_quiet #(
  parameter int unsigned EXP_W  = 11,
  parameter int unsigned FRAC_W = 52,
  localparam int unsigned WORD_W = EXP_W + FRAC_W + 1,
  localparam int unsigned IND    = FRAC_W - 1,
  localparam int unsigned ALT    = FRAC_W - 2
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic              is_snan_i,
  input  logic              nan2008_i,
  input  logic              quiet_req_i,
  output logic [WORD_W-1:0] result_o,
  output logic              invalid_o
);
  logic              do_quiet;
  logic [FRAC_W-1:0] frac_in;
  logic [FRAC_W-1:0] frac_new;
  logic [FRAC_W-1:0] frac_cleared;

  assign do_quiet     = quiet_req_i & is_snan_i;
  assign frac_in      = word_i[FRAC_W-1:0];
  assign frac_cleared = frac_in & ~(FRAC_W'(1) << IND);

  always_comb begin
    if (nan2008_i) begin
      frac_new = frac_in | (FRAC_W'(1) << IND);
    end else if (frac_cleared == '0) begin
      frac_new = frac_cleared | (FRAC_W'(1) << ALT);
    end else begin
      frac_new = frac_cleared;
    end
  end

  assign result_o  = do_quiet ? {word_i[WORD_W-1:FRAC_W], frac_new} : word_i;
  assign invalid_o = do_quiet;

  always_comb begin
    p_result_quiet_r7: assert (!invalid_o || (result_o[IND] == nan2008_i))
      else $error("quieted result still signaling");
    p_result_nan_r8: assert (!invalid_o || (result_o[FRAC_W-1:0] != '0))
      else $error("quieted result lost its NaN payload");
    p_sign_kept_r10: assert (result_o[WORD_W-1] == word_i[WORD_W-1])
      else $error("sign bit altered");
    p_passthru_r9: assert (invalid_o || (result_o == word_i))
      else $error("operand changed without quieting");
  end
endmodule

// File: rtl/dp_nan_quieter.sv
module dp_nan_quieter
  import fpq_pkg::*;
#(
  parameter int unsigned EXP_W  = 11,
  parameter int unsigned FRAC_W = 52,
  localparam int unsigned WORD_W = EXP_W + FRAC_W + 1
) (
  input  logic [WORD_W-1:0] opnd_i,
  input  logic              nan2008_i,
  input  logic              quiet_req_i,
  output logic [2:0]        class_o,
  output logic [WORD_W-1:0] result_o,
  output logic              invalid_o
);
  logic              sign;
  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic              exp_zero;
  logic              exp_ones;
  logic              frac_zero;
  logic              is_snan;
  fp_class_e         cls;

  fpq_fields #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_fields (
    .word_i      (opnd_i),
    .sign_o      (sign),
    .exp_o       (exp_f),
    .frac_o      (frac_f),
    .exp_zero_o  (exp_zero),
    .exp_ones_o  (exp_ones),
    .frac_zero_o (frac_zero)
  );

  fpq_classify #(.FRAC_W(FRAC_W)) u_classify (
    .frac_i      (frac_f),
    .exp_zero_i  (exp_zero),
    .exp_ones_i  (exp_ones),
    .frac_zero_i (frac_zero),
    .nan2008_i   (nan2008_i),
    .class_o     (cls),
    .is_snan_o   (is_snan)
  );

  fpq_quiet #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_quiet (
    .word_i      (opnd_i),
    .is_snan_i   (is_snan),
    .nan2008_i   (nan2008_i),
    .quiet_req_i (quiet_req_i),
    .result_o    (result_o),
    .invalid_o   (invalid_o)
  );

  assign class_o = cls;

  always_comb begin
    p_class_range_r6: assert (class_o <= 3'd5)
      else $error("class code out of range: %0d", class_o);
    p_flag_snan_r9: assert (!invalid_o || (quiet_req_i && exp_ones && !frac_zero))
      else $error("invalid raised for a non-NaN operand");
    p_sign_top_r10: assert (result_o[WORD_W-1] == sign)
      else $error("sign changed at top");
  end
endmodule

// File: tb/dp_nan_quieter_tb_top.sv
module dp_nan_quieter_tb_top;
  localparam int unsigned EW = 3;
  localparam int unsigned FW = 4;
  localparam int unsigned W  = EW + FW + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [W-1:0] opnd;
  logic         mode;
  logic         qreq;
  logic [2:0]   cls;
  logic [W-1:0] res;
  logic         inv;

  logic [63:0] opnd64;
  logic        mode64;
  logic        qreq64;
  logic [2:0]  cls64;
  logic [63:0] res64;
  logic        inv64;

  int checks   = 0;
  int failures = 0;
  int cycles   = 0;
  bit done     = 1'b0;

  dp_nan_quieter #(.EXP_W(EW), .FRAC_W(FW)) dut_i (
    .opnd_i(opnd), .nan2008_i(mode), .quiet_req_i(qreq),
    .class_o(cls), .result_o(res), .invalid_o(inv)
  );

  dp_nan_quieter dut64_i (
    .opnd_i(opnd64), .nan2008_i(mode64), .quiet_req_i(qreq64),
    .class_o(cls64), .result_o(res64), .invalid_o(inv64)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
    end
  endtask

  function automatic string cls_req(input int c);
    case (c)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3: return "R4";
      default: return "R5";
    endcase
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    opnd = '0; mode = 1'b0; qreq = 1'b0;
    opnd64 = '0; mode64 = 1'b0; qreq64 = 1'b0;
    repeat (2) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 idle class", {61'd0, cls}, 64'd0);
    check("R10 idle result", {56'd0, res}, 64'd0);
    check("R9 idle flag", {63'd0, inv}, 64'd0);

    for (int v = 0; v < (1 << W); v++) begin
      for (int m = 0; m < 2; m++) begin
        for (int q = 0; q < 2; q++) begin
          int e, f, s, ec, ind;
          int er, ei;
          bit snan;
          e = (v >> FW) & ((1 << EW) - 1);
          f = v & ((1 << FW) - 1);
          s = (v >> (W - 1)) & 1;
          ind = (f >> (FW - 1)) & 1;
          if (e == 0) ec = (f == 0) ? 0 : 1;
          else if (e == (1 << EW) - 1) begin
            if (f == 0) ec = 3;
            else ec = ((m == 1) == (ind == 1)) ? 4 : 5;
          end else ec = 2;
          snan = (ec == 5);
          er = v; ei = 0;
          if (q == 1 && snan) begin
            int nf;
            ei = 1;
            if (m == 1) nf = f + (1 << (FW - 1));
            else begin
              nf = f - (1 << (FW - 1));
              if (nf == 0) nf = 1 << (FW - 2);
            end
            er = (s << (W - 1)) | (e << FW) | nf;
          end
          opnd = W'(v); mode = m[0]; qreq = q[0];
          @(negedge clk);
          check(cls_req(ec), {61'd0, cls}, 64'(ec));
          check("R6 range", {63'd0, (cls <= 3'd5)}, 64'd1);
          check("R9 flag", {63'd0, inv}, 64'(ei));
          if (ei == 1) check(m == 1 ? "R7 quiet2008" : "R8 quietlegacy", {56'd0, res}, 64'(er));
          else check("R10 passthru", {56'd0, res}, 64'(er));
        end
      end
    end

    // 64-bit layout: legacy sNaN with only indicator set -> fallback bit 50 (R8)
    opnd64 = 64'h7FF8_0000_0000_0000; mode64 = 1'b0; qreq64 = 1'b1;
    @(negedge clk);
    check("R5 64 legacy snan", {61'd0, cls64}, 64'd5);
    check("R8 64 fallback", res64, 64'h7FF4_0000_0000_0000);
    check("R9 64 flag", {63'd0, inv64}, 64'd1);
    opnd64 = 64'hFFF0_0000_0000_0001; mode64 = 1'b1;
    @(negedge clk);
    check("R7 64 set bit51", res64, 64'hFFF8_0000_0000_0001);
    opnd64 = 64'hFFF8_0000_0000_0001; mode64 = 1'b0;
    @(negedge clk);
    check("R8 64 clear bit51", res64, 64'hFFF0_0000_0000_0001);
    opnd64 = 64'h7FF8_0000_0000_0000; mode64 = 1'b1;
    @(negedge clk);
    check("R5 64 quiet 2008", {61'd0, cls64}, 64'd4);
    check("R10 64 no change", res64, 64'h7FF8_0000_0000_0000);
    opnd64 = 64'h3FF0_0000_0000_0000;
    @(negedge clk);
    check("R3 64 normal", {61'd0, cls64}, 64'd2);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule